// File: doc/BRIEF.md
# Scan-out Line Address Generator

This block gives the display fetch engine the frame-buffer address of every scanline. Software writes a start location and a line pitch through a small register-write port. The timing generator supplies two strobes: one at the start of each frame and one at the start of each line. From these the block keeps a running word address for the current line, plus a 2-bit byte pan that tells the pixel pipeline how many bytes of the first word to skip.

Addresses are counted in 32-bit words. The pitch is held in 8-byte units, so each line step adds twice the pitch in words. A start-address write first goes into a holding copy. The copy is moved into use only at the next frame strobe, so the picture never tears partway through a frame.

There are two addressing modes. In the wide mode the full 30-bit word address is used. In the narrow mode the start address is built from four short fields, and every address wraps inside a 32 MB window.

Top module: `scanout_addr_gen`

## Requirements
- R1: While reset is held and after its release, `line_addr` is 0 and `byte_pan` is 0 until the first frame strobe.
- R2: One cycle after `frame_start`, `line_addr` equals the held start word address, taken in wide mode from byte-address bits 31:2 of a write with `wr_sel`=0.
- R3: The first `line_start` after a frame strobe leaves `line_addr` unchanged. Each later `line_start` adds 2×pitch words, with the result visible one cycle after the strobe.
- R4: Start, pan and mode writes change neither `line_addr` nor `byte_pan` before the next `frame_start`.
- R5: A pitch write (`wr_sel`=1) takes `wr_data[10:0]` as bytes-per-row divided by 8 and ignores the higher bits. It applies from the next line step, even within the current frame.
- R6: A pan write (`wr_sel`=6) takes `wr_data[2:1]` as byte-address bits 1:0. The value appears on `byte_pan` one cycle after the next `frame_start`.
- R7: The narrow start fields form the word address as follows: `wr_sel`=2 gives bits 7:0, `wr_sel`=3 gives bits 15:8, `wr_sel`=4 gives bits 20:16 (from `wr_data[4:0]`), and `wr_sel`=5 gives bits 22:21 (from `wr_data[1:0]`).
- R8: Mode is set by `wr_sel`=7 with `wr_data[0]` (1 = narrow) and is taken up at the next frame strobe. In narrow mode the start address and each line address are reduced modulo 2^23 words.
- R9: In wide mode the line address wraps modulo 2^30 words.
- R10: When `frame_start` and `line_start` arrive in the same cycle, the frame strobe wins: `line_addr` becomes the start address and the next `line_start` does not step.
- R11: A start write in the same cycle as `frame_start` is not used for that frame. It takes effect at the following frame strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle strobe at the start of vertical retrace / new frame |
| line_start | input | 1 | One-cycle strobe at the start of each active line |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 3 | Register select |
| wr_data | input | 32 | Register write data |
| line_addr | output | 30 | Word address of the current line |
| byte_pan | output | 2 | Byte offset within the first word |

## Verification
The assertions assume that the strobes are single-cycle pulses. They also assume that `line_start` arrives only after a frame strobe has loaded a start address, since a line step before any frame is legal but has no reference value. The stimulus raises each strobe for exactly one cycle and always opens a frame before stepping lines. It changes inputs on the falling edge, and it checks the held-until-frame behaviour by observing the outputs between a write and the next frame strobe.

// File: rtl/scanout_addr_gen.sv
module scanout_addr_gen #(
  parameter int DATA_W  = 32,
  parameter int PITCH_W = 11,
  parameter int SEL_W   = 3,
  parameter int LO_W    = 8,
  parameter int HI_W    = 8,
  parameter int X5_W    = 5,
  parameter int X2_W    = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frame_start,
  input  logic                     line_start,
  input  logic                     wr_en,
  input  logic [SEL_W-1:0]         wr_sel,
  input  logic [DATA_W-1:0]        wr_data,
  output logic [DATA_W-3:0]        line_addr,
  output logic [1:0]               byte_pan
);

  localparam int PAN_W    = 2;
  localparam int WADDR_W  = DATA_W - PAN_W;
  localparam int NARROW_W = LO_W + HI_W + X5_W + X2_W;
  localparam int B_HI     = LO_W;
  localparam int B_X5     = LO_W + HI_W;
  localparam int B_X2     = LO_W + HI_W + X5_W;
  localparam logic [WADDR_W-1:0] NARROW_MASK =
    {{(WADDR_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  localparam logic [SEL_W-1:0] SEL_START = 0;
  localparam logic [SEL_W-1:0] SEL_PITCH = 1;
  localparam logic [SEL_W-1:0] SEL_NLO   = 2;
  localparam logic [SEL_W-1:0] SEL_NHI   = 3;
  localparam logic [SEL_W-1:0] SEL_NX5   = 4;
  localparam logic [SEL_W-1:0] SEL_NX2   = 5;
  localparam logic [SEL_W-1:0] SEL_PAN   = 6;
  localparam logic [SEL_W-1:0] SEL_MODE  = 7;

  logic [WADDR_W-1:0] start_pend;
  logic [PAN_W-1:0]   pan_pend;
  logic               narrow_pend;
  logic               narrow_act;
  logic [PITCH_W-1:0] pitch;
  logic               first_line;

  logic [WADDR_W-1:0] load_addr;
  logic [WADDR_W-1:0] step;
  logic [WADDR_W-1:0] sum;
  logic [WADDR_W-1:0] next_line;

  assign load_addr = narrow_pend ? (start_pend & NARROW_MASK) : start_pend;
  assign step      = {{(WADDR_W-PITCH_W-1){1'b0}}, pitch, 1'b0};
  assign sum       = line_addr + step;
  assign next_line = narrow_act ? (sum & NARROW_MASK) : sum;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_pend  <= '0;
      pan_pend    <= '0;
      narrow_pend <= 1'b0;
      pitch       <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_START: start_pend <= wr_data[DATA_W-1:PAN_W];
        SEL_PITCH: pitch <= wr_data[PITCH_W-1:0];
        SEL_NLO:   start_pend[B_HI-1:0] <= wr_data[LO_W-1:0];
        SEL_NHI:   start_pend[B_X5-1:B_HI] <= wr_data[HI_W-1:0];
        SEL_NX5:   start_pend[B_X2-1:B_X5] <= wr_data[X5_W-1:0];
        SEL_NX2:   start_pend[NARROW_W-1:B_X2] <= wr_data[X2_W-1:0];
        SEL_PAN:   pan_pend <= wr_data[PAN_W:1];
        SEL_MODE:  narrow_pend <= wr_data[0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_addr  <= '0;
      byte_pan   <= '0;
      narrow_act <= 1'b0;
      first_line <= 1'b1;
    end else if (frame_start) begin
      line_addr  <= load_addr;
      byte_pan   <= pan_pend;
      narrow_act <= narrow_pend;
      first_line <= 1'b1;
    end else if (line_start) begin
      first_line <= 1'b0;
      if (!first_line) line_addr <= next_line;
    end
  end

  a_r2_frame_load: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> line_addr == $past(load_addr));

  a_r3_line_step: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && !frame_start && !first_line) |=>
      line_addr == ($past(narrow_act) ?
        (($past(line_addr) + {$past(pitch), 1'b0}) & NARROW_MASK) :
        ($past(line_addr) + {$past(pitch), 1'b0})));

  a_r4_hold_between_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && !line_start) |=> $stable(line_addr));

  a_r6_pan_frame_only: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(byte_pan));

  a_r8_narrow_window: assert property (@(posedge clk) disable iff (!rst_n)
    narrow_act |-> (line_addr & ~NARROW_MASK) == '0);

  a_r10_frame_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && line_start) |=> first_line);

endmodule

// File: tb/tb_scanout_addr_gen.sv
module tb_scanout_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic        line_start = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [29:0] line_addr;
  logic [1:0]  byte_pan;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  scanout_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .line_addr(line_addr), .byte_pan(byte_pan)
  );

  localparam int NV = 5;
  localparam logic        T_NARROW [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
  localparam logic [31:0] T_START  [NV] = '{32'h0000_1000, 32'h0001_2345, 32'hFFFF_FF00,
                                            32'h01FF_FF00, 32'hABCD_1230};
  localparam logic [10:0] T_PITCH  [NV] = '{11'd160, 11'h7FF, 11'h040, 11'h040, 11'h000};
  localparam logic [29:0] T_EXP0   [NV] = '{30'h400, 30'h48D1, 30'h3FFF_FFC0,
                                            30'h7F_FFC0, 30'h73_448C};
  localparam logic [29:0] T_EXP2   [NV] = '{30'h680, 30'h68CD, 30'h0C0,
                                            30'h0C0, 30'h73_448C};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic frame();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic line();
    @(negedge clk); line_start = 1'b1;
    @(negedge clk); line_start = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset addr", 32'(line_addr), 0);
    chk("R1 reset pan", 32'(byte_pan), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release addr", 32'(line_addr), 0);
    chk("R1 after release pan", 32'(byte_pan), 0);

    for (int i = 0; i < NV; i++) begin
      logic [29:0] e1;
      wr(3'd7, {31'd0, T_NARROW[i]});
      wr(3'd0, T_START[i]);
      wr(3'd1, {21'd0, T_PITCH[i]});
      frame();
      chk("R2 frame load", 32'(line_addr), 32'(T_EXP0[i]));
      line();
      chk("R3 first line no step", 32'(line_addr), 32'(T_EXP0[i]));
      line();
      e1 = T_EXP0[i] + {18'd0, T_PITCH[i], 1'b0};
      if (T_NARROW[i]) e1 = e1 & 30'h7F_FFFF;
      chk("R3 second line", 32'(line_addr), 32'(e1));
      line();
      chk(T_NARROW[i] ? "R8 narrow wrap line" : "R9 wide wrap line",
          32'(line_addr), 32'(T_EXP2[i]));
    end

    // R7 narrow field assembly
    wr(3'd7, 32'd1);
    wr(3'd0, 32'hFFFF_FFFC);
    wr(3'd2, 32'hFFFF_FF12);
    wr(3'd3, 32'h0000_0034);
    wr(3'd4, 32'hFFFF_FFF5);
    wr(3'd5, 32'h0000_0003);
    frame();
    chk("R7 narrow fields", 32'(line_addr), 32'h0075_3412);

    // R4 / R6 deferred start and pan
    wr(3'd7, 32'd0);
    wr(3'd1, 32'd4);
    wr(3'd0, 32'h0000_8000);
    wr(3'd6, 32'hFFFF_FFF6);
    chk("R4 start held", 32'(line_addr), 32'h0075_3412);
    chk("R4 pan held", 32'(byte_pan), 0);
    line();
    line();
    chk("R4 step uses old base", 32'(line_addr), 32'h0075_341A);
    frame();
    chk("R2 deferred start applied", 32'(line_addr), 32'h2000);
    chk("R6 pan applied", 32'(byte_pan), 3);
    wr(3'd6, 32'hFFFF_FFF2);
    frame();
    chk("R6 pan bits 2:1 only", 32'(byte_pan), 1);

    // R5 pitch upper bits ignored, applied mid-frame
    line();
    wr(3'd1, 32'hFFFF_F801);
    line();
    chk("R5 pitch masked", 32'(line_addr), 32'h2002);

    // R10 simultaneous strobes
    line();
    @(negedge clk); frame_start = 1'b1; line_start = 1'b1;
    @(negedge clk); frame_start = 1'b0; line_start = 1'b0;
    chk("R10 frame wins", 32'(line_addr), 32'h2000);
    line();
    chk("R10 next line no step", 32'(line_addr), 32'h2000);

    // R11 write coincident with frame strobe
    @(negedge clk); frame_start = 1'b1; wr_en = 1'b1; wr_sel = 3'd0; wr_data = 32'h0000_4000;
    @(negedge clk); frame_start = 1'b0; wr_en = 1'b0;
    chk("R11 coincident write not used", 32'(line_addr), 32'h2000);
    frame();
    chk("R11 used next frame", 32'(line_addr), 32'h1000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule